// File: doc/BRIEF.md
# BCD Real-Time Calendar Core

This core keeps wall-clock time and calendar date in packed BCD. A fast or slow reference clock is divided down to one advance pulse per second by two cascaded down-counters: a short first stage and a long second stage, each with its own reload value. Each pulse steps seconds, then minutes, hours, day of month, month and a two-digit year. A weekday counter (Monday = 1 through Sunday = 7) runs beside the date. Months have their true length, and February gets 29 days in years divisible by four.

Software or a neighbouring block loads the time word, the date word and the divider word through three one-cycle write strobes that share one data bus. A hold input freezes the calendar and parks both dividers at their reload values. A separate block uses this while it rewrites the calendar. A status output reports whether the calendar has been set, judged by a nonzero year.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time word is 0x000000, the date word is 0x002101 (day 01, month 01, weekday 1, year 00), the divider word holds the reset reload values (0x7F00FF with defaults), and the tick and the set flag are 0.
- R2: The divider word carries the first-stage reload A in bits 22:16 and the second-stage reload S in bits 14:0, and reads 0 elsewhere. While hold is low, `sec_tick_o` pulses once every (A+1)*(S+1) clock cycles.
- R3: Seconds sit in time bits 6:0 as BCD. A low digit of 9 steps to the next tens value, and 0x59 rolls to 0x00 with a carry into minutes.
- R4: Minutes sit in time bits 14:8 and roll from 0x59 to 0x00 into hours. Hours sit in bits 21:16, count 0x00 to 0x23 and roll to 0x00 with a carry into the date.
- R5: The weekday sits in date bits 15:13, encoded 1 = Monday to 7 = Sunday. It steps on every day carry, and 7 wraps to 1.
- R6: The day of month sits in date bits 5:0. Months 0x04, 0x06, 0x09 and 0x11 end after day 0x30, all months other than February end after 0x31, and the day then returns to 0x01.
- R7: February ends after day 0x29 when the BCD year is divisible by four (00 included), and after 0x28 otherwise.
- R8: The month sits in date bits 12:8 and steps in BCD (0x09 to 0x10). 0x12 wraps to 0x01 and steps the year in bits 23:16, which wraps from 0x99 to 0x00.
- R9: `init_done_o` is 1 exactly when the year field is nonzero.
- R10: While `hold_i` is high, time and date do not change and no tick is issued. After hold falls, the first tick comes (A+1)*(S+1)-1 cycles later, as a full period measured from the reloaded dividers.
- R11: A write strobe loads its word from `wr_data_i` in the field positions above, with unused bits read as 0. A divider write also restarts both stages. A tick that coincides with any write strobe is dropped, so the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock feeding the divider chain |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_i | input | 1 | Freeze calendar and park dividers |
| wr_time_i | input | 1 | Load the time word from wr_data_i |
| wr_date_i | input | 1 | Load the date word from wr_data_i |
| wr_presc_i | input | 1 | Load the divider word and restart both stages |
| wr_data_i | input | 24 | Shared write data |
| time_o | output | 24 | Packed BCD time word |
| date_o | output | 24 | Packed BCD date word with weekday |
| presc_o | output | 24 | Divider reload word |
| sec_tick_o | output | 1 | One-cycle pulse at each calendar advance |
| init_done_o | output | 1 | Calendar set flag (year nonzero) |

## Verification
The rarest conditions are the end-of-month, end-of-February and end-of-year carries. At one tick per second these would take simulated days to reach. The stimulus raises hold, writes a time one second before midnight together with a chosen date, sets a short divider period, drops hold and samples right after the first tick. Because the stimulus goes in under hold, no tick can fall between the two loads. The dropped-tick rule needs a tick on the same edge as a write. The bench gets this by setting both reloads to zero, so that every cycle ticks, and releasing hold on the very cycle it strobes a write.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

   localparam int WORD_W = 24;

   // BCD step of a two-digit value; callers handle the wrap themselves
   function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // true when a two-digit BCD year is a multiple of four
   function automatic logic bcd_year_div4(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic logic [5:0] month_last_day(input logic [4:0] m, input logic feb29);
      case (m)
         5'h02:                      return feb29 ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

   // time-of-day digit pairs: 0 = seconds, 1 = minutes, 2 = hours
   function automatic int time_width(input int idx);
      return (idx == 2) ? 6 : 7;
   endfunction

   function automatic logic [7:0] time_limit(input int idx);
      return (idx == 2) ? 8'h23 : 8'h59;
   endfunction

endpackage

// File: rtl/bcd_cal_prescaler.sv
module bcd_cal_prescaler #(
   parameter int ADIV_W = 7,
   parameter int SDIV_W = 15,
   parameter int A_RST  = 127,
   parameter int S_RST  = 255
) (
   input  logic              clk_i,
   input  logic              rst_n,
   input  logic              hold_i,
   input  logic              load_i,
   input  logic [ADIV_W-1:0] a_new_i,
   input  logic [SDIV_W-1:0] s_new_i,
   output logic [ADIV_W-1:0] a_rld_o,
   output logic [SDIV_W-1:0] s_rld_o,
   output logic              tick_o
);

   logic [ADIV_W-1:0] a_cnt_q;
   logic [SDIV_W-1:0] s_cnt_q;
   logic              a_zero;
   logic              s_zero;

   assign a_zero = (a_cnt_q == '0);
   assign s_zero = (s_cnt_q == '0);
   assign tick_o = !hold_i && a_zero && s_zero;

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
         a_rld_o <= ADIV_W'(A_RST);
         s_rld_o <= SDIV_W'(S_RST);
         a_cnt_q <= ADIV_W'(A_RST);
         s_cnt_q <= SDIV_W'(S_RST);
      end else if (load_i) begin
         a_rld_o <= a_new_i;
         s_rld_o <= s_new_i;
         a_cnt_q <= a_new_i;
         s_cnt_q <= s_new_i;
      end else if (hold_i) begin
         a_cnt_q <= a_rld_o;
         s_cnt_q <= s_rld_o;
      end else if (a_zero) begin
         a_cnt_q <= a_rld_o;
         s_cnt_q <= s_zero ? s_rld_o : s_cnt_q - SDIV_W'(1);
      end else begin
         a_cnt_q <= a_cnt_q - ADIV_W'(1);
      end
   end

endmodule

// File: rtl/bcd_cal_time.sv
module bcd_cal_time
   import bcd_cal_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_word_i,
   output logic [WORD_W-1:0] time_o,
   output logic              day_carry_o
);

   localparam int UNITS = 3;

   logic [UNITS:0] carry;
   assign carry[0]    = adv_i;
   assign day_carry_o = carry[UNITS];

   wire unused_pad_bits = ^{load_word_i[23:22], load_word_i[15], load_word_i[7]};

   for (genvar u = 0; u < UNITS; u++) begin : g_unit
      localparam int         W   = time_width(u);
      localparam logic [7:0] LIM = time_limit(u);

      logic [W-1:0] val_q;
      logic         at_lim;

      assign at_lim       = (8'(val_q) == LIM);
      assign carry[u+1]   = carry[u] && at_lim;
      assign time_o[u*8 +: W] = val_q;

      if (W < 8) begin : g_pad
         assign time_o[u*8+W +: 8-W] = '0;
      end

      always_ff @(posedge clk_i or negedge rst_n) begin
         if (!rst_n)        val_q <= '0;
         else if (load_i)   val_q <= load_word_i[u*8 +: W];
         else if (carry[u]) val_q <= at_lim ? '0 : W'(bcd_inc8(8'(val_q)));
      end
   end

endmodule

// File: rtl/bcd_cal_date.sv
module bcd_cal_date
   import bcd_cal_pkg::*;
#(
   parameter bit LEAP_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_word_i,
   output logic [WORD_W-1:0] date_o
);

   logic [5:0] day_q;
   logic [4:0] mon_q;
   logic [2:0] wday_q;
   logic [7:0] year_q;
   logic       feb29;
   logic [5:0] last_day;
   logic       month_end;
   logic       year_end;

   wire unused_pad_bits = ^load_word_i[7:6];

   if (LEAP_EN) begin : g_leap
      assign feb29 = bcd_year_div4(year_q);
   end else begin : g_no_leap
      assign feb29 = 1'b0;
   end

   assign last_day  = month_last_day(mon_q, feb29);
   assign month_end = (day_q == last_day);
   assign year_end  = month_end && (mon_q == 5'h12);
   assign date_o    = {year_q, wday_q, mon_q, 2'b00, day_q};

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
         day_q  <= 6'h01;
         mon_q  <= 5'h01;
         wday_q <= 3'd1;
         year_q <= 8'h00;
      end else if (load_i) begin
         day_q  <= load_word_i[5:0];
         mon_q  <= load_word_i[12:8];
         wday_q <= load_word_i[15:13];
         year_q <= load_word_i[23:16];
      end else if (adv_i) begin
         wday_q <= (wday_q == 3'd7) ? 3'd1 : wday_q + 3'd1;
         day_q  <= month_end ? 6'h01 : 6'(bcd_inc8(8'(day_q)));
         if (month_end)
            mon_q <= (mon_q == 5'h12) ? 5'h01 : 5'(bcd_inc8(8'(mon_q)));
         if (year_end)
            year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc8(year_q);
      end
   end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import bcd_cal_pkg::*;
#(
   parameter int ADIV_W  = 7,
   parameter int SDIV_W  = 15,
   parameter int A_RST   = 127,
   parameter int S_RST   = 255,
   parameter bit LEAP_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_n,
   input  logic              hold_i,
   input  logic              wr_time_i,
   input  logic              wr_date_i,
   input  logic              wr_presc_i,
   input  logic [WORD_W-1:0] wr_data_i,
   output logic [WORD_W-1:0] time_o,
   output logic [WORD_W-1:0] date_o,
   output logic [WORD_W-1:0] presc_o,
   output logic              sec_tick_o,
   output logic              init_done_o
);

   localparam int A_POS = 16;
   localparam int S_POS = 0;

   if (ADIV_W < 1 || ADIV_W > 8) begin : g_bad_adiv
      $error("ADIV_W must lie in 1..8");
   end
   if (SDIV_W < 1 || SDIV_W > 16) begin : g_bad_sdiv
      $error("SDIV_W must lie in 1..16");
   end
   if (A_RST < 0 || A_RST >= (1 << ADIV_W)) begin : g_bad_arst
      $error("A_RST does not fit ADIV_W");
   end
   if (S_RST < 0 || S_RST >= (1 << SDIV_W)) begin : g_bad_srst
      $error("S_RST does not fit SDIV_W");
   end

   logic [ADIV_W-1:0] a_rld;
   logic [SDIV_W-1:0] s_rld;
   logic              tick;
   logic              any_wr;
   logic              advance;
   logic              day_carry;

   assign any_wr  = wr_time_i || wr_date_i || wr_presc_i;
   assign advance = tick && !any_wr;

   bcd_cal_prescaler #(
      .ADIV_W (ADIV_W),
      .SDIV_W (SDIV_W),
      .A_RST  (A_RST),
      .S_RST  (S_RST)
   ) u_div (
      .clk_i   (clk_i),
      .rst_n   (rst_n),
      .hold_i  (hold_i),
      .load_i  (wr_presc_i),
      .a_new_i (wr_data_i[A_POS +: ADIV_W]),
      .s_new_i (wr_data_i[S_POS +: SDIV_W]),
      .a_rld_o (a_rld),
      .s_rld_o (s_rld),
      .tick_o  (tick)
   );

   bcd_cal_time u_time (
      .clk_i       (clk_i),
      .rst_n       (rst_n),
      .adv_i       (advance),
      .load_i      (wr_time_i),
      .load_word_i (wr_data_i),
      .time_o      (time_o),
      .day_carry_o (day_carry)
   );

   bcd_cal_date #(
      .LEAP_EN (LEAP_EN)
   ) u_date (
      .clk_i       (clk_i),
      .rst_n       (rst_n),
      .adv_i       (day_carry),
      .load_i      (wr_date_i),
      .load_word_i (wr_data_i),
      .date_o      (date_o)
   );

   always_comb begin
      presc_o                   = '0;
      presc_o[A_POS +: ADIV_W]  = a_rld;
      presc_o[S_POS +: SDIV_W]  = s_rld;
   end

   assign sec_tick_o  = tick;
   assign init_done_o = |date_o[23:16];

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
   input logic        clk_i,
   input logic        rst_n,
   input logic        hold_i,
   input logic        wr_time_i,
   input logic        wr_date_i,
   input logic        wr_presc_i,
   input logic [23:0] wr_data_i,
   input logic [23:0] time_o,
   input logic [23:0] date_o,
   input logic        sec_tick_o
);

   // R11: a time write lands in the next cycle, pad bits cleared
   a_r11_time_write_loads: assert property (@(posedge clk_i) disable iff (!rst_n)
      wr_time_i |=> time_o == ($past(wr_data_i) & 24'h3F7F7F));

   // R11: a date write lands in the next cycle, pad bits cleared
   a_r11_date_write_loads: assert property (@(posedge clk_i) disable iff (!rst_n)
      wr_date_i |=> date_o == ($past(wr_data_i) & 24'hFFFF3F));

   // R10: hold freezes the calendar
   a_r10_hold_freezes: assert property (@(posedge clk_i) disable iff (!rst_n)
      (hold_i && !wr_time_i && !wr_date_i) |=> ($stable(time_o) && $stable(date_o)));

   // R3: without a tick the time word does not move
   a_r3_still_without_tick: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!sec_tick_o && !wr_time_i) |=> $stable(time_o));

   // R3: a tick below a units digit of 9 adds one second
   a_r3_sec_step: assert property (@(posedge clk_i) disable iff (!rst_n)
      (sec_tick_o && !wr_time_i && !wr_date_i && !wr_presc_i && time_o[3:0] != 4'h9)
      |=> time_o[6:0] == $past(time_o[6:0]) + 7'd1);

   // R4: hours never leave 00..23
   a_r4_hour_range: assert property (@(posedge clk_i) disable iff (!rst_n)
      time_o[21:16] <= 6'h23);

   // R5: weekday code never reads 0
   a_r5_weekday_nonzero: assert property (@(posedge clk_i) disable iff (!rst_n)
      date_o[15:13] != 3'd0);

endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
   .clk_i      (clk_i),
   .rst_n      (rst_n),
   .hold_i     (hold_i),
   .wr_time_i  (wr_time_i),
   .wr_date_i  (wr_date_i),
   .wr_presc_i (wr_presc_i),
   .wr_data_i  (wr_data_i),
   .time_o     (time_o),
   .date_o     (date_o),
   .sec_tick_o (sec_tick_o)
);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold = 1'b0;
   logic        wr_time = 1'b0;
   logic        wr_date = 1'b0;
   logic        wr_presc = 1'b0;
   logic [23:0] wr_data = '0;
   logic [23:0] time_w;
   logic [23:0] date_w;
   logic [23:0] presc_w;
   logic        tick;
   logic        init_done;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   bcd_calendar u_bcd_calendar (
      .clk_i       (clk),
      .rst_n       (rst_n),
      .hold_i      (hold),
      .wr_time_i   (wr_time),
      .wr_date_i   (wr_date),
      .wr_presc_i  (wr_presc),
      .wr_data_i   (wr_data),
      .time_o      (time_w),
      .date_o      (date_w),
      .presc_o     (presc_w),
      .sec_tick_o  (tick),
      .init_done_o (init_done)
   );

   localparam int NV = 17;
   // seconds/minutes/hours carries (R3, R4), month ends (R6), February (R7),
   // year wrap (R8), weekday wrap (R5)
   localparam logic [23:0] V_T_IN [NV] = '{
      24'h000000, 24'h000009, 24'h000059, 24'h005959, 24'h095959, 24'h235959,
      24'h235959, 24'h235959, 24'h235959, 24'h235959, 24'h235959, 24'h235959,
      24'h235959, 24'h235959, 24'h235959, 24'h195959, 24'h235959};
   localparam logic [23:0] V_D_IN [NV] = '{
      24'h242101, 24'h242101, 24'h242101, 24'h242101, 24'h242101, 24'h246131,
      24'h24E228, 24'h242229, 24'h234228, 24'h258430, 24'h25A530, 24'h99D231,
      24'h092930, 24'h195231, 24'h002228, 24'h242101, 24'h126228};
   localparam logic [23:0] V_T_EXP [NV] = '{
      24'h000001, 24'h000010, 24'h000100, 24'h010000, 24'h100000, 24'h000000,
      24'h000000, 24'h000000, 24'h000000, 24'h000000, 24'h000000, 24'h000000,
      24'h000000, 24'h000000, 24'h000000, 24'h200000, 24'h000000};
   localparam logic [23:0] V_D_EXP [NV] = '{
      24'h242101, 24'h242101, 24'h242101, 24'h242101, 24'h242101, 24'h248201,
      24'h242229, 24'h244301, 24'h236301, 24'h25A501, 24'h25C531, 24'h00E101,
      24'h095001, 24'h206101, 24'h004229, 24'h242101, 24'h128229};

   task automatic check(input string what, input logic [23:0] act, input logic [23:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", what, act, exp);
      end
   endtask

   // 0 = time, 1 = date, 2 = divider; ends on the negedge after capture
   task automatic put(input int kind, input logic [23:0] d);
      @(negedge clk);
      wr_data  = d;
      wr_time  = (kind == 0);
      wr_date  = (kind == 1);
      wr_presc = (kind == 2);
      @(negedge clk);
      wr_time  = 1'b0;
      wr_date  = 1'b0;
      wr_presc = 1'b0;
   endtask

   task automatic wait_tick();
      int guard = 0;
      while (!tick && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_fails++;
      n_checks++;
      $display("FAIL watchdog expired before the run ended");
      finish_run();
   end

   initial begin
      int cnt;
      bit seen;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 time after reset", time_w, 24'h000000);
      check("R1 date after reset", date_w, 24'h002101);
      check("R1 divider after reset", presc_w, 24'h7F00FF);
      check("R1 tick after reset", {23'd0, tick}, 24'd0);
      check("R1 set flag after reset", {23'd0, init_done}, 24'd0);

      // R2 field masking and readback
      put(2, 24'hFFFFFF);
      check("R2 divider masked readback", presc_w, 24'h7F7FFF);
      put(2, 24'h020003);
      check("R2 divider readback", presc_w, 24'h020003);
      wait_tick();
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!tick && cnt < 100);
      check("R2 tick period A=2 S=3", 24'(cnt), 24'd12);

      // table of single-tick steps
      put(2, 24'h010000);
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         hold = 1'b1;
         put(0, V_T_IN[i]);
         put(1, V_D_IN[i]);
         hold = 1'b0;
         wait_tick();
         @(negedge clk);
         check($sformatf("table %0d time (R3 R4)", i), time_w, V_T_EXP[i]);
         check($sformatf("table %0d date (R5 R6 R7 R8)", i), date_w, V_D_EXP[i]);
         check($sformatf("table %0d set flag (R9)", i), {23'd0, init_done},
               {23'd0, (V_D_EXP[i][23:16] != 8'h00)});
      end

      // R10 hold freezes and parks the dividers
      @(negedge clk);
      hold = 1'b1;
      put(2, 24'h010001);
      put(0, 24'h123456);
      seen = 1'b0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (tick) seen = 1'b1;
      end
      check("R10 time frozen under hold", time_w, 24'h123456);
      check("R10 no tick under hold", {23'd0, seen}, 24'd0);
      hold = 1'b0;
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!tick && cnt < 100);
      check("R10 first tick after release", 24'(cnt), 24'd3);
      @(negedge clk);
      check("R10 time resumes", time_w, 24'h123457);

      // R11 tick coinciding with a write is dropped
      hold = 1'b1;
      put(2, 24'h000000);
      put(0, 24'h235959);
      wr_data = 24'h242315;
      wr_date = 1'b1;
      hold    = 1'b0;
      @(negedge clk);
      wr_date = 1'b0;
      check("R11 time kept on write edge", time_w, 24'h235959);
      check("R11 date written on tick edge", date_w, 24'h242315);
      @(negedge clk);
      check("R11 time after next tick", time_w, 24'h000000);
      check("R11 date after next tick", date_w, 24'h244316);
      wr_data = 24'h000010;
      wr_time = 1'b1;
      @(negedge clk);
      wr_time = 1'b0;
      check("R11 time write wins over tick", time_w, 24'h000010);
      hold = 1'b1;
      @(negedge clk);
      check("R9 set flag with year 24", {23'd0, init_done}, 24'd1);

      finish_run();
   end

endmodule